// File: doc/BRIEF.md
# Phase-aligned bus acknowledge generator

This block produces the active-low transfer acknowledge for a bus master that reaches a shared memory. The memory runs in fixed slots timed by two quadrature reference clocks, C1 and C3. The block runs on a system clock at four times the reference rate. On every system clock edge it samples the reference levels and looks for the falling edge of the address strobe.

A strobe that falls while both references are low starts a counted slot at once. The acknowledge comes on the fourth tick of that slot, counting the tick of the fall as the first. A strobe that falls in any other phase gets wait states: the request is held until the next tick with both references low, and the same count then runs. In this way the master cycle is pulled onto the memory slot rather than given a fixed latency.

A ready input lets a slow device hold off the acknowledge. An override input takes the acknowledge pin away from the block. The tristate is modelled as an output enable plus an active-low data bit.

Top module: `sync_ack_gen`

## Requirements
- R1: When the strobe fall is sampled on an edge where c1_i=0 and c3_i=0, ack_no goes low after the third following edge. This is the fourth tick, counting the fall edge as tick one.
- R2: When the strobe fall is sampled with c1_i=1 and c3_i=1, no count starts. The count begins on the next edge with both references low, and ack_no goes low three edges after that. With references following the sequence (c1,c3)=00,10,11,01, this is five edges after the fall.
- R3: A fall sampled in either mixed phase (10 or 01) also waits for the next both-low edge. In the sequence 00,10,11,01 this gives six edges after the fall for 10 and four edges after the fall for 01.
- R4: While rdy_i is low, ack_no stays high. Once the count is complete, ack_no goes low in the same cycle that rdy_i returns high.
- R5: While ovr_ni is low, ack_oe_o is 0 and ack_no is 1, regardless of all other acknowledge logic. Releasing ovr_ni restores the acknowledge at once, and the slot count is unaffected.
- R6: ack_no is high whenever as_ni is high. The block is idle on the next edge and ready for a new access.
- R7: If the strobe is released before the acknowledge, the pending access is dropped. The next access is timed afresh.
- R8: While rst_ni is low, the block is idle with ack_no=1. ack_oe_o equals 1 when ovr_ni is high.
- R9: While ovr_ni is high, ack_oe_o is 1, so the block drives the acknowledge as an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, four times the reference rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| c1_i | input | 1 | Reference phase clock C1 |
| c3_i | input | 1 | Reference phase clock C3, in quadrature with C1 |
| as_ni | input | 1 | Address strobe from the bus master, active low |
| rdy_i | input | 1 | Ready from slow devices; low holds off the acknowledge |
| ovr_ni | input | 1 | Override, active low; releases the acknowledge pin |
| ack_no | output | 1 | Acknowledge data bit, active low |
| ack_oe_o | output | 1 | Acknowledge output enable |

## Verification
Two functions can land in the same cycle: the override and the slot count reaching its final tick. The bench asserts ovr_ni on exactly the sample where an in-sync access would first show the acknowledge. It requires ack_oe_o low and ack_no high at that point. It then releases the override one tick later and requires the acknowledge to appear in that same sample. In a similar way, ready returning high is placed both before and after the count completes. This shows whether the later of the two events alone sets the acknowledge time.

// File: rtl/sync_ack_pkg.sv
package sync_ack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_COUNT = 2'd2,
    ST_ACK   = 2'd3
  } slot_st_e;
endpackage

// File: rtl/sync_phase_det.sv
module sync_phase_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic as_ni,
  input  logic c1_i,
  input  logic c3_i,
  output logic as_fall_o,
  output logic as_high_o,
  output logic slot_start_o
);
  logic as_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) as_q <= 1'b1;
    else         as_q <= as_ni;
  end

  assign as_fall_o    = as_q & ~as_ni;
  assign as_high_o    = as_ni;
  // both references low marks the first tick of a memory slot
  assign slot_start_o = ~c1_i & ~c3_i;
endmodule

// File: rtl/sync_slot_cnt.sv
module sync_slot_cnt
  import sync_ack_pkg::*;
#(
  parameter int unsigned TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic as_fall_i,
  input  logic as_high_i,
  input  logic slot_start_i,
  output logic ack_state_o
);
  localparam int unsigned CW = (TICKS > 2) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  slot_st_e      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (as_fall_i) begin
          if (slot_start_i) begin
            st_d  = ST_COUNT;
            cnt_d = CW'(1);
          end else begin
            st_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (as_high_i) st_d = ST_IDLE;
        else if (slot_start_i) begin
          st_d  = ST_COUNT;
          cnt_d = CW'(1);
        end
      end
      ST_COUNT: begin
        if (as_high_i)          st_d = ST_IDLE;
        else if (cnt_q == LAST) st_d = ST_ACK;
        else                    cnt_d = cnt_q + CW'(1);
      end
      ST_ACK: begin
        if (as_high_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign ack_state_o = (st_q == ST_ACK);
endmodule

// File: rtl/sync_ack_drv.sv
module sync_ack_drv (
  input  logic ack_state_i,
  input  logic rdy_i,
  input  logic as_ni,
  input  logic ovr_ni,
  output logic ack_no,
  output logic ack_oe_o
);
  logic ack_act;

  // ready and strobe gate combinationally so hold-off and release are immediate
  assign ack_act  = ack_state_i & rdy_i & ~as_ni;
  // override wins over everything: pin released, data bit parked high
  assign ack_oe_o = ovr_ni;
  assign ack_no   = ~(ack_act & ovr_ni);
endmodule

// File: rtl/sync_ack_gen.sv
module sync_ack_gen #(
  parameter int unsigned TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic c1_i,
  input  logic c3_i,
  input  logic as_ni,
  input  logic rdy_i,
  input  logic ovr_ni,
  output logic ack_no,
  output logic ack_oe_o
);
  logic as_fall, as_high, slot_start, ack_state;

  sync_phase_det u_det (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .as_ni       (as_ni),
    .c1_i        (c1_i),
    .c3_i        (c3_i),
    .as_fall_o   (as_fall),
    .as_high_o   (as_high),
    .slot_start_o(slot_start)
  );

  sync_slot_cnt #(.TICKS(TICKS)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .as_fall_i   (as_fall),
    .as_high_i   (as_high),
    .slot_start_i(slot_start),
    .ack_state_o (ack_state)
  );

  sync_ack_drv u_drv (
    .ack_state_i(ack_state),
    .rdy_i      (rdy_i),
    .as_ni      (as_ni),
    .ovr_ni     (ovr_ni),
    .ack_no     (ack_no),
    .ack_oe_o   (ack_oe_o)
  );
endmodule

// File: rtl/sync_ack_gen_chk.sv
module sync_ack_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic c1_i,
  input logic c3_i,
  input logic as_ni,
  input logic rdy_i,
  input logic ovr_ni,
  input logic ack_no,
  input logic ack_oe_o
);
  // R1
  min_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_no |-> (!$past(as_ni, 1) && !$past(as_ni, 2) && !$past(as_ni, 3)));

  // R2
  aligned_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_no && $past(ack_no) && rdy_i && $past(rdy_i) && ovr_ni && $past(ovr_ni)
     && !as_ni && !$past(as_ni)) |-> $past(!c1_i && !c3_i, 4));

  // R4
  rdy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_i |-> ack_no);

  // R5
  ovr_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovr_ni |-> (!ack_oe_o && ack_no));

  // R6
  as_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(as_ni) |-> ack_no);

  // R9
  drive_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_ni |-> ack_oe_o);
endmodule

bind sync_ack_gen sync_ack_gen_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .c1_i    (c1_i),
  .c3_i    (c3_i),
  .as_ni   (as_ni),
  .rdy_i   (rdy_i),
  .ovr_ni  (ovr_ni),
  .ack_no  (ack_no),
  .ack_oe_o(ack_oe_o)
);

// File: tb/sync_ack_gen_bench.sv
module sync_ack_gen_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic as_ni = 1'b1;
  logic rdy_i = 1'b1;
  logic ovr_ni = 1'b1;
  logic c1_i, c3_i;
  logic ack_no, ack_oe_o;
  logic [1:0] ph = 2'd0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  // reference phase sequence (c1,c3): 00,10,11,01
  always @(negedge clk_i) ph <= ph + 2'd1;
  assign c1_i = (ph == 2'd1) || (ph == 2'd2);
  assign c3_i = (ph == 2'd2) || (ph == 2'd3);

  sync_ack_gen u_sync_ack_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .c1_i    (c1_i),
    .c3_i    (c3_i),
    .as_ni   (as_ni),
    .rdy_i   (rdy_i),
    .ovr_ni  (ovr_ni),
    .ack_no  (ack_no),
    .ack_oe_o(ack_oe_o)
  );

  // {pad, phase at fall, ready rise sample (0 = always ready), expected first ack sample}
  localparam logic [11:0] VEC [7] = '{
    12'h003, 12'h106, 12'h205, 12'h304, 12'h077, 12'h288, 12'h225
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    #1;
  endtask

  task automatic wait_phase(input logic [1:0] target);
    do step(); while (ph != target);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int first;
    int k;
    bit oe_bad;
    logic [1:0] vph;
    int rr, ex;
    string req;

    repeat (3) step();
    chk(ack_no == 1'b1, "R8 reset ack_no", ack_no, 1);
    chk(ack_oe_o == 1'b1, "R8 reset ack_oe_o", ack_oe_o, 1);
    rst_ni = 1'b1;
    repeat (2) step();

    for (int v = 0; v < 7; v++) begin
      vph = VEC[v][9:8];
      rr  = int'(VEC[v][7:4]);
      ex  = int'(VEC[v][3:0]);
      req = (rr != 0) ? "R4" : (vph == 2'd0) ? "R1" : (vph == 2'd2) ? "R2" : "R3";
      wait_phase(vph);
      as_ni = 1'b0;
      if (rr != 0) rdy_i = 1'b0;
      first = -1;
      k = 0;
      oe_bad = 1'b0;
      while (first < 0 && k < 16) begin
        step();
        if (rr != 0 && k == rr) rdy_i = 1'b1;
        #1;
        if (!ack_oe_o) oe_bad = 1'b1;
        if (!ack_no) first = k;
        k++;
      end
      chk(first == ex, {req, " ack latency"}, first, ex);
      if (rr != 0) chk(first >= rr, "R4 held off while not ready", first, rr);
      chk(!oe_bad, "R9 output enabled", oe_bad, 0);
      as_ni = 1'b1;
      #1;
      chk(ack_no == 1'b1, "R6 immediate release", ack_no, 1);
      step();
      chk(ack_no == 1'b1, "R6 idle after release", ack_no, 1);
      rdy_i = 1'b1;
    end

    // R5: override lands on the tick the acknowledge would first appear
    wait_phase(2'd0);
    as_ni = 1'b0;
    for (int i = 0; i < 3; i++) step();
    step();
    ovr_ni = 1'b0;
    #1;
    chk(ack_oe_o == 1'b0, "R5 override disables", ack_oe_o, 0);
    chk(ack_no == 1'b1, "R5 override parks bit high", ack_no, 1);
    step();
    ovr_ni = 1'b1;
    #1;
    chk(ack_no == 1'b0, "R5 ack restored after override", ack_no, 0);
    chk(ack_oe_o == 1'b1, "R9 enable restored", ack_oe_o, 1);
    as_ni = 1'b1;
    step();

    // R7: release during the wait, then a fresh in-sync access
    wait_phase(2'd1);
    as_ni = 1'b0;
    step();
    step();
    as_ni = 1'b1;
    first = 0;
    for (int i = 0; i < 8; i++) begin
      step();
      if (!ack_no) first = 1;
    end
    chk(first == 0, "R7 dropped access no ack", first, 0);
    wait_phase(2'd0);
    as_ni = 1'b0;
    first = -1;
    for (int i = 0; i < 8; i++) begin
      step();
      if (first < 0 && !ack_no) first = i;
    end
    chk(first == 3, "R7 fresh access latency", first, 3);

    // R8: reset during acknowledge
    rst_ni = 1'b0;
    #1;
    chk(ack_no == 1'b1, "R8 reset clears ack", ack_no, 1);
    chk(ack_oe_o == 1'b1, "R8 reset enable", ack_oe_o, 1);
    as_ni = 1'b1;
    step();
    rst_ni = 1'b1;
    step();
    chk(ack_no == 1'b1, "R8 idle after reset", ack_no, 1);

    finish_run();
  end
endmodule